// File: doc/BRIEF.md
# Floating-Point Resource Reservation Scoreboard

This block decides, one cycle at a time, whether a floating-point or integer-multiply operation may start. It models six shared hardware resources: four floating-point pipeline stages (F0, F1, F2, F3) and two interchangeable multiplier sub-units. Each operation class occupies these resources in a fixed pattern over the cycles after issue. The block keeps a window of resources already promised to earlier operations. Each clock, this window moves one step closer to the present.

An issue stage presents a request with a 3-bit class code. The scoreboard expands the class into its per-cycle resource pattern and compares that pattern against the window.

- If no cycle collides, it raises `accept` and ORs the pattern into the window.
- If any cycle collides, it raises `stall` and records nothing.

For integer multiplies, it picks the first multiplier sub-unit that is free, falling back to the second. Alongside the decision it reports the result latency of the presented class, so that dependent operations can be timed. The datapath and register writeback are outside this block.

Top module: `fpres_scoreboard`

## Requirements
- R1: Reset (`rst` high at a clock edge) clears every reservation, so the first request after reset is accepted whatever its class.
- R2: `stall` is high exactly when `req_valid` is high and the pattern collides with the window; `accept` is high exactly when `req_valid` is high and it does not. With `req_valid` low, both are low. Both outputs are combinational from the request and the current window.
- R3: Class code 0 (single-precision arithmetic) reserves F0 and F1 at offset 1 and F2 at offset 2; its latency is 3.
- R4: Class code 1 (double-precision conversion) reserves F0+F1 at offset 1, F1+F2 at offset 2 and F2 at offset 3; its latency is 4.
- R5: Class code 2 (double-precision add, subtract, multiply) reserves F0+F1 at offset 1, F1+F2 at offsets 2 to 6 and F2 at offset 7; its latency is 8.
- R6: Class code 3 (single-precision divide) reserves the following; its latency is 12.
  - F0+F1+F3 at offset 1
  - F2+F3 at offset 2
  - F3 alone at offsets 3 to 9
  - F1+F3 at offset 10
  - F2 at offset 11
- R7: Class code 4 (double-precision divide) reserves the following; its latency is 25.
  - F0+F1+F3 at offset 1
  - F1+F2+F3 at offset 2
  - F2+F3 at offset 3
  - F3 alone at offsets 4 to 19
  - F1+F3 at offset 20
  - F1+F2+F3 at offsets 21 and 22
  - F2 at offset 23
- R8: Class code 5 (integer multiply) reserves one multiplier sub-unit at offsets 1 to 4 and F2 at offset 5; its latency is 4. The first sub-unit is used when all four of its cycles are clear, otherwise the second. `mul_sel` is 0 for the first sub-unit and 1 for the second.
- R9: No cycle may hold F1 together with either multiplier sub-unit; a request that would create such a cycle is stalled.
- R10: Class code 6 (FPSCR load) reserves nothing at offset 1 and F1 at offsets 2 to 4; its latency is 4.
- R11: Offset k of an accepted pattern refers to the k-th clock after the request cycle. A stalled request leaves the window unchanged, and the window moves one cycle toward the present every clock.
- R12: Class code 7 reserves nothing, reports latency 0 and is always accepted when valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An operation asks to issue this cycle |
| req_op | input | 3 | Operation class code (see R3 to R12) |
| accept | output | 1 | Operation issues; its pattern is recorded |
| stall | output | 1 | Operation collides and must wait |
| mul_sel | output | 1 | Multiplier sub-unit chosen for a class-5 request |
| latency | output | 5 | Result latency of the presented class |

## Verification
Back-to-back pairs of the same class separate classes that pipeline freely, such as single arithmetic, from classes that block their own successor on F1, such as conversion and double arithmetic. Repeated divides held against shorter classes show how long F3 stays exclusive. Chains of three multiplies check the fallback to the second sub-unit and the stall when both are taken. Multiplies placed next to FPSCR loads check the exclusion with F1. A long random stream of mixed classes and idle cycles checks that stalled requests leave no trace and that the window shifts correctly.

// File: rtl/fpres_pkg.sv
package fpres_pkg;

    localparam int LAT_W    = 5;
    localparam int MAX_SPAN = 23;

    typedef enum logic [2:0] {
        OP_SARITH = 3'd0,
        OP_DCONV  = 3'd1,
        OP_DARITH = 3'd2,
        OP_SDIV   = 3'd3,
        OP_DDIV   = 3'd4,
        OP_IMUL   = 3'd5,
        OP_FPSCR  = 3'd6,
        OP_NONE   = 3'd7
    } fp_op_e;

    typedef struct packed {
        logic mul_b;
        logic mul_a;
        logic f3;
        logic f2;
        logic f1;
        logic f0;
    } fp_res_t;

    // Resources a class claims k cycles after its issue cycle.
    function automatic fp_res_t class_use(fp_op_e op, int unsigned k, logic alt_mul);
        fp_res_t r;
        r = '0;
        unique case (op)
            OP_SARITH: begin
                r.f0 = (k == 1);
                r.f1 = (k == 1);
                r.f2 = (k == 2);
            end
            OP_DCONV: begin
                r.f0 = (k == 1);
                r.f1 = (k == 1) || (k == 2);
                r.f2 = (k == 2) || (k == 3);
            end
            OP_DARITH: begin
                r.f0 = (k == 1);
                r.f1 = (k >= 1) && (k <= 6);
                r.f2 = (k >= 2) && (k <= 7);
            end
            OP_SDIV: begin
                r.f0 = (k == 1);
                r.f1 = (k == 1) || (k == 10);
                r.f2 = (k == 2) || (k == 11);
                r.f3 = (k >= 1) && (k <= 10);
            end
            OP_DDIV: begin
                r.f0 = (k == 1);
                r.f1 = (k == 1) || (k == 2) || ((k >= 20) && (k <= 22));
                r.f2 = (k == 2) || (k == 3) || ((k >= 21) && (k <= 23));
                r.f3 = (k >= 1) && (k <= 22);
            end
            OP_IMUL: begin
                r.mul_a = !alt_mul && (k >= 1) && (k <= 4);
                r.mul_b =  alt_mul && (k >= 1) && (k <= 4);
                r.f2    = (k == 5);
            end
            OP_FPSCR: begin
                r.f1 = (k >= 2) && (k <= 4);
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [LAT_W-1:0] class_latency(fp_op_e op);
        unique case (op)
            OP_SARITH: return 5'd3;
            OP_DCONV:  return 5'd4;
            OP_DARITH: return 5'd8;
            OP_SDIV:   return 5'd12;
            OP_DDIV:   return 5'd25;
            OP_IMUL:   return 5'd4;
            OP_FPSCR:  return 5'd4;
            default:   return 5'd0;
        endcase
    endfunction

    // Same-resource overlap, or F1 meeting a multiplier sub-unit.
    function automatic logic clash(fp_res_t held, fp_res_t want);
        logic same, excl;
        same = (held & want) != '0;
        excl = (held.f1 && (want.mul_a || want.mul_b)) ||
               (want.f1 && (held.mul_a || held.mul_b));
        return same || excl;
    endfunction

endpackage

// File: rtl/fpres_pattern.sv
module fpres_pattern
    import fpres_pkg::*;
#(
    parameter int DEPTH = 26
) (
    input  fp_op_e  op,
    input  logic    alt_mul,
    output fp_res_t pat [DEPTH]
);
    for (genvar k = 0; k < DEPTH; k++) begin : g_off
        assign pat[k] = class_use(op, k, alt_mul);
    end
endmodule

// File: rtl/fpres_conflict.sv
module fpres_conflict
    import fpres_pkg::*;
#(
    parameter int DEPTH = 26
) (
    input  fp_res_t held [DEPTH],
    input  fp_res_t want [DEPTH],
    output logic    hit
);
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            hit = hit | clash(held[i], want[i]);
        end
    end
endmodule

// File: rtl/fpres_window.sv
module fpres_window
    import fpres_pkg::*;
#(
    parameter int DEPTH = 26
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    merge_en,
    input  fp_res_t add  [DEPTH],
    output fp_res_t held [DEPTH]
);
    // held[i]: resources promised to the cycle i clocks from now.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i < DEPTH - 1) begin : g_mid
            always_ff @(posedge clk) begin
                if (rst)
                    held[i] <= '0;
                else if (merge_en)
                    held[i] <= fp_res_t'(held[i+1] | add[i+1]);
                else
                    held[i] <= held[i+1];
            end

            // R11
            shift_chk: assert property (@(posedge clk) disable iff (rst)
                !merge_en |=> held[i] == $past(held[i+1]));
        end else begin : g_last
            always_ff @(posedge clk) begin
                held[i] <= '0;
            end
        end

        // R1
        clear_chk: assert property (@(posedge clk) rst |=> held[i] == '0);

        // R9
        excl_chk: assert property (@(posedge clk) disable iff (rst)
            !(held[i].f1 && (held[i].mul_a || held[i].mul_b)));
    end
endmodule

// File: rtl/fpres_scoreboard.sv
module fpres_scoreboard
    import fpres_pkg::*;
#(
    parameter int DEPTH = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    output logic             accept,
    output logic             stall,
    output logic             mul_sel,
    output logic [LAT_W-1:0] latency
);
    localparam int N_MUL = 2;

    fp_op_e  op;
    fp_res_t held   [DEPTH];
    fp_res_t cand   [N_MUL][DEPTH];
    fp_res_t chosen [DEPTH];
    logic [N_MUL-1:0] hit;

    assign op = fp_op_e'(req_op);

    // One candidate pattern per multiplier sub-unit; identical for other classes.
    for (genvar u = 0; u < N_MUL; u++) begin : g_cand
        fpres_pattern #(.DEPTH(DEPTH)) u_pat (
            .op      (op),
            .alt_mul (1'(u)),
            .pat     (cand[u])
        );
        fpres_conflict #(.DEPTH(DEPTH)) u_chk (
            .held (held),
            .want (cand[u]),
            .hit  (hit[u])
        );
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            chosen[i] = hit[0] ? cand[1][i] : cand[0][i];
        end
    end

    assign stall   = req_valid && (&hit);
    assign accept  = req_valid && !(&hit);
    assign mul_sel = (op == OP_IMUL) && hit[0];
    assign latency = class_latency(op);

    fpres_window #(.DEPTH(DEPTH)) u_win (
        .clk      (clk),
        .rst      (rst),
        .merge_en (accept),
        .add      (chosen),
        .held     (held)
    );

    // R2
    stall_accept_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(stall && accept));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!stall && !accept));

    // R6
    div_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_SDIV) ##1 (req_valid && op == OP_DDIV) |-> stall);

    // R12
    lat_defined_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op != OP_NONE) |-> latency != '0);
endmodule

// File: tb/fpres_scoreboard_bench.sv
module fpres_scoreboard_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = 3'd0;
    logic       accept, stall, mul_sel;
    logic [4:0] latency;

    int vectors = 0;
    int miscompares = 0;
    longint now = 0;
    bit [5:0] occ [longint];

    localparam bit [5:0] M_F0 = 6'd1, M_F1 = 6'd2, M_F2 = 6'd4, M_F3 = 6'd8,
                         M_MA = 6'd16, M_MB = 6'd32;

    always #5 clk = ~clk;

    fpres_scoreboard u_fpres_scoreboard (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .accept(accept), .stall(stall), .mul_sel(mul_sel), .latency(latency)
    );

    function automatic void seg(ref bit [5:0] q[$], input bit [5:0] m, input int n);
        for (int i = 0; i < n; i++) q.push_back(m);
    endfunction

    function automatic void build(input bit [2:0] op, input bit alt, ref bit [5:0] q[$]);
        bit [5:0] mm;
        mm = alt ? M_MB : M_MA;
        q = {};
        q.push_back(6'd0);
        case (op)
            3'd0: begin seg(q, M_F0|M_F1, 1); seg(q, M_F2, 1); end
            3'd1: begin seg(q, M_F0|M_F1, 1); seg(q, M_F1|M_F2, 1); seg(q, M_F2, 1); end
            3'd2: begin seg(q, M_F0|M_F1, 1); seg(q, M_F1|M_F2, 5); seg(q, M_F2, 1); end
            3'd3: begin
                seg(q, M_F0|M_F1|M_F3, 1); seg(q, M_F2|M_F3, 1); seg(q, M_F3, 7);
                seg(q, M_F1|M_F3, 1); seg(q, M_F2, 1);
            end
            3'd4: begin
                seg(q, M_F0|M_F1|M_F3, 1); seg(q, M_F1|M_F2|M_F3, 1); seg(q, M_F2|M_F3, 1);
                seg(q, M_F3, 16); seg(q, M_F1|M_F3, 1); seg(q, M_F1|M_F2|M_F3, 2);
                seg(q, M_F2, 1);
            end
            3'd5: begin seg(q, mm, 4); seg(q, M_F2, 1); end
            3'd6: begin seg(q, 6'd0, 1); seg(q, M_F1, 3); end
            default: ;
        endcase
    endfunction

    function automatic bit [5:0] held_at(longint t);
        return occ.exists(t) ? occ[t] : 6'd0;
    endfunction

    function automatic bit fits(ref bit [5:0] q[$]);
        for (int j = 1; j < q.size(); j++) begin
            bit [5:0] h;
            h = held_at(now + j);
            if ((h & q[j]) != 0) return 1'b0;
            if (h[1] && q[j][5:4] != 0) return 1'b0;
            if (q[j][1] && h[5:4] != 0) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic int exp_lat(bit [2:0] op);
        case (op)
            3'd0: return 3;
            3'd1, 3'd5, 3'd6: return 4;
            3'd2: return 8;
            3'd3: return 12;
            3'd4: return 25;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, now);
        end
    endtask

    task automatic step(input bit v, input bit [2:0] op, input string tag);
        bit [5:0] qa[$];
        bit [5:0] qb[$];
        bit ok_a, ok_b, ok;
        @(negedge clk);
        req_valid = v;
        req_op = op;
        #1;
        build(op, 1'b0, qa);
        build(op, 1'b1, qb);
        ok_a = fits(qa);
        ok_b = fits(qb);
        ok = ok_a || ok_b;
        check(tag, "accept", int'(accept), int'(v && ok));
        check(tag, "stall", int'(stall), int'(v && !ok));
        check(tag, "latency", int'(latency), exp_lat(op));
        if (v && ok && op == 3'd5) check("R8", "mul_sel", int'(mul_sel), int'(!ok_a));
        @(posedge clk);
        if (v && ok) begin
            for (int j = 1; j < qa.size(); j++)
                occ[now + j] = held_at(now + j) | (ok_a ? qa[j] : qb[j]);
        end
        if (occ.exists(now)) occ.delete(now);
        now++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, "R2");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        occ.delete();
        #1;
        check("R1", "accept in reset", int'(accept), 0);
        check("R1", "stall in reset", int'(stall), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        do_reset();
        step(1'b1, 3'd4, "R1");
        // R7: shorter classes against a running double divide
        for (int i = 0; i < 24; i++) step(1'b1, 3'(i % 4), "R7");
        step(1'b1, 3'd4, "R7");
        step(1'b1, 3'd4, "R7");
        // R1: reset in mid-stream, then immediate acceptance
        do_reset();
        step(1'b1, 3'd4, "R1");
        do_reset();
        // R3
        step(1'b1, 3'd0, "R3"); step(1'b1, 3'd0, "R3"); step(1'b1, 3'd0, "R3");
        idle(4);
        // R4
        for (int i = 0; i < 4; i++) step(1'b1, 3'd1, "R4");
        idle(4);
        // R5
        for (int i = 0; i < 10; i++) step(1'b1, 3'd2, "R5");
        idle(10);
        // R6
        for (int i = 0; i < 14; i++) step(1'b1, 3'd3, "R6");
        step(1'b1, 3'd4, "R6");
        idle(26);
        // R8
        step(1'b1, 3'd5, "R8"); step(1'b1, 3'd5, "R8"); step(1'b1, 3'd5, "R8");
        step(1'b1, 3'd5, "R8");
        idle(8);
        // R9
        step(1'b1, 3'd6, "R9"); step(1'b1, 3'd5, "R9"); step(1'b1, 3'd5, "R9");
        idle(6);
        step(1'b1, 3'd5, "R9"); step(1'b1, 3'd6, "R9"); step(1'b1, 3'd2, "R9");
        idle(8);
        // R10
        step(1'b1, 3'd6, "R10"); step(1'b1, 3'd0, "R10"); step(1'b1, 3'd6, "R10");
        idle(6);
        // R11: stalled request must leave nothing behind
        step(1'b1, 3'd3, "R11"); step(1'b1, 3'd3, "R11"); step(1'b1, 3'd0, "R11");
        idle(12);
        step(1'b1, 3'd0, "R11");
        // R12
        step(1'b1, 3'd4, "R12"); step(1'b1, 3'd7, "R12"); step(1'b1, 3'd7, "R12");
        idle(26);
        // R2: mixed random stream
        for (int i = 0; i < 3000; i++) begin
            bit v;
            v = ($urandom_range(0, 9) < 7);
            step(v, 3'($urandom_range(0, 7)), "R2");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule